// File: doc/BRIEF.md
# Vertical Window Line Buffer with Edge Mirroring

This block sits in front of a column-direction wavelet filter core. It takes an image tile as a raster stream, one pixel per valid beat and one row after another, and turns it into a stream of five-sample vertical windows. Each window holds the pixels of one column from five consecutive rows around an even centre row. The column filter therefore runs before the row filter, and no full frame has to be stored. Running the columns first is what keeps the integer output identical to the usual software transform. The other order produces least-significant-bit rounding differences.

Five line buffers, each one row of `IMG_W` pixels wide, hold the recent rows. The buffers rotate: every new row goes into the buffer that holds the oldest row, so writing a row never collides with the reads of the same cycle. Where a window reaches past the top or bottom edge of the tile, the tap multiplexers substitute mirrored rows. The column filter decimates by two, so windows are issued only on even centre rows. After the last row of a tile, the block issues the final row of windows by itself. The next tile's pixels may already be arriving while this happens. `IMG_W` is a parameter, so the same structure serves the smaller sub-images of deeper decomposition levels.

Top module: `vmc_column_window`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_vld` is low. The block then expects pixel 0 of row 0 of a new tile.
- R2: A pixel is taken on every rising edge where `in_vld` is high, in raster order: `IMG_W` pixels per row and `IMG_H` rows per tile. Cycles with `in_vld` low change nothing, and gaps of any length are allowed.
- R3: A window is centred on an even tile row c and one column x. Tap k sits at bits `[k*DW +: DW]` of `out_win`, for k = 0 to 4, and holds the pixel of row c-2+k in column x. Tap 0 is therefore the topmost row.
- R4: The window with centre c and column x is issued when column x of row c+2 is taken, for every c with c+2 <= `IMG_H`-1. It is visible on the outputs after the next rising edge. Rows 0 and 1 and every odd row issue no window.
- R5: Rows above the tile are mirrored, so row -1 reads as row 1 and row -2 as row 2. The window of centre 0 therefore carries rows 2,1,0,1,2.
- R6: Rows below the tile are mirrored, so row `IMG_H` reads as row `IMG_H`-2 and row `IMG_H`+1 as row `IMG_H`-3.
- R7: The last centre row (`IMG_H`-2 for an even height, `IMG_H`-1 for an odd height) is issued without further input. Its window for column j is visible after the rising edge j+2 counted from the edge that takes the tile's last pixel.
- R8: Pixels of the next tile may arrive while that final row of windows is being issued, with no gap, and no pixel or window is lost or reordered.
- R9: Each tile yields exactly `IMG_W` * ceil(`IMG_H`/2) windows, in order of centre row and then column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Pixel on `in_pix` is taken at this edge |
| in_pix | input | DW | Raster pixel |
| out_vld | output | 1 | `out_win` holds a window this cycle |
| out_win | output | 5*DW | Five vertically aligned samples, tap 0 topmost |

## Verification
The bench drives two instances from one long raster stream, one with an odd and one with an even tile height, so both forms of bottom mirroring and both flush lengths are covered. The first part of the stream has random gaps between pixels, which tests that idle cycles neither advance nor disturb the row sequencing. The second part has no gaps at all, so a new tile starts on the edge right after the last pixel of the previous one and overlaps the flush. Rows of all-ones and all-zeros are mixed with random rows, so a wrong tap or buffer slot shows up as a wrong value. The arrival cycle of every window is also checked, which separates windows driven by the live pixel from flush windows.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
  localparam int TAPS  = 5;
  localparam int SLOTS = 5;

  typedef enum logic [1:0] {
    WIN_TOP,
    WIN_BODY,
    WIN_TAIL_EVEN,
    WIN_TAIL_ODD
  } win_kind_e;

  function automatic logic [2:0] slot_back(input logic [2:0] base, input int age);
    int s;
    s = (int'(base) + SLOTS - age) % SLOTS;
    return 3'(s);
  endfunction
endpackage

// File: rtl/vmc_linebuf.sv
module vmc_linebuf #(
  parameter int DW    = 10,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vmc_seq.sv
module vmc_seq
  import vmc_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 64,
  localparam int CW   = $clog2(IMG_W),
  localparam int RW   = $clog2(IMG_H)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  output logic          wr_en,
  output logic [2:0]    wr_slot,
  output logic [CW-1:0] wr_addr,
  output logic          rd_en,
  output logic [CW-1:0] rd_addr,
  output logic          iss_vld,
  output win_kind_e     iss_kind,
  output logic [2:0]    iss_base,
  output logic          fl_act,
  output logic [CW-1:0] fl_col,
  output logic [RW-1:0] row_idx
);
  localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);
  localparam win_kind_e TAIL_KIND = (IMG_H % 2 == 0) ? WIN_TAIL_EVEN : WIN_TAIL_ODD;

  logic [CW-1:0] col;
  logic [2:0]    slot, fl_base, next_slot;
  logic          live_win;

  assign next_slot = (slot == 3'd4) ? 3'd0 : slot + 3'd1;
  assign live_win  = in_vld && !row_idx[0] && (row_idx >= RW'(2));

  assign wr_en    = in_vld;
  assign wr_slot  = slot;
  assign wr_addr  = col;
  assign iss_vld  = live_win || fl_act;
  assign rd_en    = iss_vld;
  assign rd_addr  = fl_act ? fl_col : col;
  assign iss_base = fl_act ? fl_base : slot;

  always_comb begin
    if (fl_act)                  iss_kind = TAIL_KIND;
    else if (row_idx == RW'(2))  iss_kind = WIN_TOP;
    else                         iss_kind = WIN_BODY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col     <= '0;
      row_idx <= '0;
      slot    <= '0;
      fl_act  <= 1'b0;
      fl_col  <= '0;
      fl_base <= '0;
    end else begin
      if (fl_act) begin
        if (fl_col == COL_LAST) fl_act <= 1'b0;
        else                    fl_col <= fl_col + CW'(1);
      end
      if (in_vld) begin
        if (col == COL_LAST) begin
          col  <= '0;
          slot <= next_slot;
          if (row_idx == ROW_LAST) begin
            row_idx <= '0;
            fl_act  <= 1'b1;
            fl_col  <= '0;
            fl_base <= next_slot;
          end else begin
            row_idx <= row_idx + RW'(1);
          end
        end else begin
          col <= col + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vmc_tapmux.sv
module vmc_tapmux
  import vmc_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   iss_vld,
  input  win_kind_e              iss_kind,
  input  logic [2:0]             iss_base,
  input  logic [DW-1:0]          live_pix,
  input  logic [SLOTS-1:0][DW-1:0] rd_data,
  output logic                   out_vld,
  output logic [TAPS*DW-1:0]     out_win
);
  logic          s1_vld;
  win_kind_e     s1_kind;
  logic [2:0]    s1_base;
  logic [DW-1:0] s1_live;
  logic [DW-1:0] age [1:4];
  logic [DW-1:0] tap [TAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_kind <= WIN_BODY;
      s1_base <= '0;
      s1_live <= '0;
    end else begin
      s1_vld <= iss_vld;
      if (iss_vld) begin
        s1_kind <= iss_kind;
        s1_base <= iss_base;
        s1_live <= live_pix;
      end
    end
  end

  for (genvar a = 1; a <= 4; a++) begin : g_age
    assign age[a] = rd_data[slot_back(s1_base, a)];
  end

  always_comb begin
    unique case (s1_kind)
      WIN_TOP:       begin tap[0] = s1_live; tap[1] = age[1]; tap[2] = age[2]; tap[3] = age[1]; tap[4] = s1_live; end
      WIN_BODY:      begin tap[0] = age[4];  tap[1] = age[3]; tap[2] = age[2]; tap[3] = age[1]; tap[4] = s1_live; end
      WIN_TAIL_EVEN: begin tap[0] = age[4];  tap[1] = age[3]; tap[2] = age[2]; tap[3] = age[1]; tap[4] = age[2];  end
      default:       begin tap[0] = age[3];  tap[1] = age[2]; tap[2] = age[1]; tap[3] = age[2]; tap[4] = age[3];  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= s1_vld;
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_out
    always_ff @(posedge clk) begin
      if (s1_vld) out_win[k*DW +: DW] <= tap[k];
    end
  end
endmodule

// File: rtl/vmc_column_window.sv
module vmc_column_window
  import vmc_pkg::*;
#(
  parameter int DW    = 10,
  parameter int IMG_W = 64,
  parameter int IMG_H = 64,
  localparam int CW   = $clog2(IMG_W),
  localparam int RW   = $clog2(IMG_H)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic [DW-1:0]      in_pix,
  output logic               out_vld,
  output logic [TAPS*DW-1:0] out_win
);
  // Tiles must be at least 3 rows high and 2 pixels wide.
  logic                    wr_en, rd_en, iss_vld, fl_act;
  logic [2:0]              wr_slot, iss_base;
  logic [CW-1:0]           wr_addr, rd_addr, fl_col;
  logic [RW-1:0]           row_idx;
  win_kind_e               iss_kind;
  logic [SLOTS-1:0][DW-1:0] rd_data;

  vmc_seq #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_seq (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .iss_vld(iss_vld), .iss_kind(iss_kind), .iss_base(iss_base),
    .fl_act(fl_act), .fl_col(fl_col), .row_idx(row_idx)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_buf
    vmc_linebuf #(.DW(DW), .DEPTH(IMG_W)) u_buf (
      .clk(clk),
      .we(wr_en && (wr_slot == 3'(g))),
      .waddr(wr_addr), .wdata(in_pix),
      .re(rd_en), .raddr(rd_addr),
      .rdata(rd_data[g])
    );
  end

  vmc_tapmux #(.DW(DW)) u_mux (
    .clk(clk), .rst(rst),
    .iss_vld(iss_vld), .iss_kind(iss_kind), .iss_base(iss_base),
    .live_pix(in_pix), .rd_data(rd_data),
    .out_vld(out_vld), .out_win(out_win)
  );
endmodule

// File: rtl/vmc_column_window_chk.sv
module vmc_column_window_chk #(
  parameter int IMG_W = 64,
  parameter int IMG_H = 64,
  localparam int CW   = $clog2(IMG_W),
  localparam int RW   = $clog2(IMG_H)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_vld,
  input logic          out_vld,
  input logic          fl_act,
  input logic [CW-1:0] fl_col,
  input logic [RW-1:0] row_idx
);
  AST_RST_QUIET: assert property (@(posedge clk) rst |=> !out_vld); // R1

  AST_ODD_ROW_SILENT: assert property (@(posedge clk) disable iff (rst)
    (in_vld && row_idx[0]) |=> ##1 !out_vld); // R4

  AST_LIVE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !row_idx[0] && row_idx >= RW'(2)) |=> ##1 out_vld); // R4

  AST_FLUSH_STREAM: assert property (@(posedge clk) disable iff (rst)
    fl_act |=> ##1 out_vld); // R7

  AST_FLUSH_SPAN: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_act) |-> $past(fl_col) == CW'(IMG_W - 1)); // R7

  AST_OVERLAP_SAFE: assert property (@(posedge clk) disable iff (rst)
    (fl_act && in_vld) |-> row_idx < RW'(2)); // R8
endmodule

bind vmc_column_window vmc_column_window_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .out_vld(out_vld),
  .fl_act(fl_act), .fl_col(fl_col), .row_idx(row_idx)
);

// File: tb/vmc_column_window_bench.sv
module vmc_column_window_bench;
  localparam int DW   = 8;
  localparam int W    = 5;
  localparam int HA   = 7;
  localparam int HB   = 6;
  localparam int ROWS = 42;
  localparam int NPIX = ROWS * W;
  localparam int NWA  = (ROWS / HA) * W * ((HA + 1) / 2);
  localparam int NWB  = (ROWS / HB) * W * ((HB + 1) / 2);
  localparam int GAP_ROWS = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [DW-1:0] in_pix = '0;
  logic out_vld_a, out_vld_b;
  logic [5*DW-1:0] out_win_a, out_win_b;

  always #5 clk = ~clk;

  vmc_column_window #(.DW(DW), .IMG_W(W), .IMG_H(HA)) u_vmc_column_window (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_pix(in_pix),
    .out_vld(out_vld_a), .out_win(out_win_a));

  vmc_column_window #(.DW(DW), .IMG_W(W), .IMG_H(HB)) u_vmc_column_window_e (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_pix(in_pix),
    .out_vld(out_vld_b), .out_win(out_win_b));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0] pix [NPIX];
  int exp_cyc_a [NWA];
  int exp_cyc_b [NWB];
  int na_q = 0, nb_q = 0, na_c = 0, nb_c = 0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  function automatic int mir(input int i, input int h);
    if (i < 0) return -i;
    if (i > h - 1) return 2 * (h - 1) - i;
    return i;
  endfunction

  function automatic logic [5*DW-1:0] exp_win(input int n, input int h);
    int per, tile, rem, c, col;
    logic [5*DW-1:0] v;
    per  = W * ((h + 1) / 2);
    tile = n / per;
    rem  = n % per;
    c    = 2 * (rem / W);
    col  = rem % W;
    for (int k = 0; k < 5; k++)
      v[k*DW +: DW] = pix[(tile * h + mir(c - 2 + k, h)) * W + col];
    return v;
  endfunction

  function automatic string tag_of(input int n, input int h, input bit timing);
    int per, tile, c;
    string t;
    per  = W * ((h + 1) / 2);
    tile = n / per;
    c    = 2 * ((n % per) / W);
    if (timing) t = (c + 2 > h - 1) ? "R7" : "R4";
    else if (c == 0) t = "R5";
    else if (c + 2 > h - 1) t = "R6";
    else t = "R3";
    t = {t, (tile * h < GAP_ROWS) ? " R2" : " R8"};
    return t;
  endfunction

  task automatic check_one(input int h, input int n, input logic [5*DW-1:0] win, input int ecyc);
    logic [5*DW-1:0] e;
    e = exp_win(n, h);
    checks++;
    if (win !== e) begin
      errors++;
      $display("FAIL %s H=%0d window %0d data got %h expected %h", tag_of(n, h, 1'b0), h, n, win, e);
    end
    checks++;
    if (cyc != ecyc) begin
      errors++;
      $display("FAIL %s H=%0d window %0d cycle got %0d expected %0d", tag_of(n, h, 1'b1), h, n, cyc, ecyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_vld_a) begin
      if (na_c < na_q) check_one(HA, na_c, out_win_a, exp_cyc_a[na_c]);
      else begin
        checks++; errors++;
        $display("FAIL R4 H=%0d unexpected window got %0d expected %0d", HA, na_c + 1, na_q);
      end
      na_c++;
    end
    if (!rst && out_vld_b) begin
      if (nb_c < nb_q) check_one(HB, nb_c, out_win_b, exp_cyc_b[nb_c]);
      else begin
        checks++; errors++;
        $display("FAIL R4 H=%0d unexpected window got %0d expected %0d", HB, nb_c + 1, nb_q);
      end
      nb_c++;
    end
  end

  task automatic send(input int gi);
    int r, c;
    logic [DW-1:0] v;
    r = gi / W;
    c = gi % W;
    if (r == 9) v = '1;
    else if (r == 16 || r == 30) v = '0;
    else v = DW'($urandom);
    @(negedge clk);
    in_vld = 1'b1;
    in_pix = v;
    pix[gi] = v;
    // live window seen at cyc+2, flush column j at cyc+3+j (R4, R7)
    if ((r % HA) % 2 == 0 && (r % HA) >= 2) begin exp_cyc_a[na_q] = cyc + 2; na_q++; end
    if ((r % HA) == HA - 1 && c == W - 1)
      for (int j = 0; j < W; j++) begin exp_cyc_a[na_q] = cyc + 3 + j; na_q++; end
    if ((r % HB) % 2 == 0 && (r % HB) >= 2) begin exp_cyc_b[nb_q] = cyc + 2; nb_q++; end
    if ((r % HB) == HB - 1 && c == W - 1)
      for (int j = 0; j < W; j++) begin exp_cyc_b[nb_q] = cyc + 3 + j; nb_q++; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    checks++;
    if (out_vld_a !== 1'b0 || out_vld_b !== 1'b0) begin
      errors++;
      $display("FAIL R1 out_vld during reset got %b%b expected 00", out_vld_a, out_vld_b);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_vld_a !== 1'b0 || out_vld_b !== 1'b0) begin
      errors++;
      $display("FAIL R1 out_vld after reset got %b%b expected 00", out_vld_a, out_vld_b);
    end
    // R2: random gaps in the first half, R8: no gaps in the second half
    for (int gi = 0; gi < NPIX; gi++) begin
      if (gi < GAP_ROWS * W && ($urandom % 4) == 0) idle(1 + ($urandom % 3));
      send(gi);
    end
    idle(30);
    checks++;
    if (na_c != NWA) begin
      errors++;
      $display("FAIL R9 H=%0d window count got %0d expected %0d", HA, na_c, NWA);
    end
    checks++;
    if (nb_c != NWB) begin
      errors++;
      $display("FAIL R9 H=%0d window count got %0d expected %0d", HB, nb_c, NWB);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected end of run");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule